// File: doc/BRIEF.md
# Exact-Match Next-Hop Lookup Stage

This block is one match-action stage of a packet pipeline. A small table, written only by the control plane, maps a 32-bit IPv4 destination address to an action. The action either forwards the packet to a next-hop address and an output port, or drops it. The data path presents one destination address per cycle. The stage compares that address against every valid entry at once. The matching entry's action runs, and a miss runs the default action, which is drop.

A drop is signalled by the reserved output port value 12'hFFF, together with a drop flag. Results come out at a fixed latency of two cycles. A new request can be accepted on every cycle, so the pipeline is fully pipelined. The control-plane write port can install, overwrite or invalidate any entry. A lookup issued on the cycle after a write already sees the new entry contents.

Top module: `nh_lookup_stage`

## Requirements
- R1: After reset, rs_valid is 0 and every table entry is invalid, so any lookup misses until an entry has been written.
- R2: A lookup hits only a valid entry whose stored key equals all 32 bits of lk_dst. A key that differs in any single bit misses.
- R3: A hit on an entry whose action code is 2'b01 (set next hop) returns rs_hit=1, rs_nhop equal to the stored next hop and rs_port equal to the stored port. When that stored port is not 12'hFFF, it also returns rs_drop=0.
- R4: A hit on an entry whose action code is anything other than 2'b01 runs the drop action: rs_hit=1, rs_drop=1, rs_port=12'hFFF and rs_nhop=0.
- R5: A miss runs the default drop action: rs_hit=0, rs_drop=1, rs_port=12'hFFF and rs_nhop=0.
- R6: A control write with cp_wr_valid=0 invalidates the entry, and that entry no longer matches any key.
- R7: When several valid entries hold the same key, the entry with the lowest index supplies the action.
- R8: A request sampled at clock edge t produces rs_valid=1 with its result after edge t+2. Requests on consecutive cycles each produce one result on consecutive cycles.
- R9: A control write sampled at edge t is seen by a lookup sampled at edge t+1 or later. A lookup sampled at the same edge t still sees the previous contents.
- R10: A set-next-hop entry whose stored port is 12'hFFF is reported as a drop: rs_drop=1, rs_port=12'hFFF and rs_nhop=0, with rs_hit=1.
- R11: Whenever rs_valid is 0, rs_hit, rs_drop, rs_nhop and rs_port are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cp_wr_en | input | 1 | Control-plane write strobe |
| cp_wr_idx | input | 4 | Entry index to write |
| cp_wr_key | input | 32 | Destination address key of the entry |
| cp_wr_act | input | 2 | Action code: 2'b01 sets the next hop, any other value drops |
| cp_wr_nhop | input | 32 | Next-hop address parameter |
| cp_wr_port | input | 12 | Output port parameter |
| cp_wr_valid | input | 1 | Valid bit of the written entry (0 invalidates it) |
| lk_req | input | 1 | Lookup request strobe |
| lk_dst | input | 32 | Destination address to look up |
| rs_valid | output | 1 | Result valid, two cycles after the request |
| rs_hit | output | 1 | A table entry matched |
| rs_drop | output | 1 | The packet is dropped |
| rs_nhop | output | 32 | Next-hop address (0 on a drop) |
| rs_port | output | 12 | Output port, 12'hFFF on a drop |

## Verification
The assertions check several properties on every cycle:
- At most one entry is ever selected, even when several entries match.
- Each request yields exactly one result, two cycles later.
- A miss always shows as a drop, and a drop never carries a next hop.
- Idle result fields stay zero.
- A write lands in the addressed entry on the next cycle.

Some behaviours depend on table history, and only the bench scenarios can show them:
- Which entry wins among duplicate keys.
- Whether an invalidated entry stops matching.
- Whether a lookup on the same edge as a write sees the old contents.
- Whether a single-bit key difference misses.

The bench compares every result against a reference table that it updates itself.

// File: rtl/nh_pkg.sv
package nh_pkg;
    localparam int KEY_W   = 32;
    localparam int PORT_W  = 12;
    localparam int ACT_W   = 2;
    localparam logic [ACT_W-1:0]  ACT_SET_NHOP = 2'b01;
    localparam logic [PORT_W-1:0] DROP_PORT    = '1;

    typedef struct packed {
        logic              valid;
        logic [KEY_W-1:0]  key;
        logic [ACT_W-1:0]  act;
        logic [KEY_W-1:0]  nhop;
        logic [PORT_W-1:0] port;
    } nh_entry_t;
endpackage

// File: rtl/nh_entry_store.sv
module nh_entry_store
    import nh_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  nh_entry_t        wr_entry,
    output nh_entry_t        tbl_o [DEPTH]
);
    nh_entry_t tbl_d [DEPTH];
    nh_entry_t tbl_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            tbl_d[i] = tbl_q[i];
        end
        if (wr_en) begin
            tbl_d[wr_idx] = wr_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl_q[i] <= tbl_d[i];
            end
        end
    end

    assign tbl_o = tbl_q;

    // R9: a write is visible in the addressed entry one edge later
    p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> tbl_q[$past(wr_idx)] == $past(wr_entry));
endmodule

// File: rtl/nh_match.sv
module nh_match
    import nh_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] key_i,
    input  nh_entry_t        tbl_i [DEPTH],
    output logic             hit_o,
    output nh_entry_t        entry_o
);
    logic [DEPTH-1:0] eq;
    logic [DEPTH-1:0] grant;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign eq[g] = tbl_i[g].valid && (tbl_i[g].key == key_i);
    end

    // isolate the lowest set bit: lowest index wins
    assign grant = eq & (~eq + 1'b1);
    assign hit_o = |eq;

    always_comb begin
        entry_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (grant[i]) begin
                entry_o = tbl_i[i];
            end
        end
    end

    // R7: never more than one entry selected
    p_single_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R7: the selected entry is one that actually matched
    p_grant_in_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~eq) == '0);
endmodule

// File: rtl/nh_lookup_stage.sv
module nh_lookup_stage
    import nh_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cp_wr_en,
    input  logic [IDX_W-1:0]  cp_wr_idx,
    input  logic [KEY_W-1:0]  cp_wr_key,
    input  logic [ACT_W-1:0]  cp_wr_act,
    input  logic [KEY_W-1:0]  cp_wr_nhop,
    input  logic [PORT_W-1:0] cp_wr_port,
    input  logic              cp_wr_valid,
    input  logic              lk_req,
    input  logic [KEY_W-1:0]  lk_dst,
    output logic              rs_valid,
    output logic              rs_hit,
    output logic              rs_drop,
    output logic [KEY_W-1:0]  rs_nhop,
    output logic [PORT_W-1:0] rs_port
);
    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [ACT_W-1:0]  act;
        logic [KEY_W-1:0]  nhop;
        logic [PORT_W-1:0] port;
    } match_stage_t;

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic              drop;
        logic [KEY_W-1:0]  nhop;
        logic [PORT_W-1:0] port;
    } result_t;

    nh_entry_t    wr_entry;
    nh_entry_t    tbl [DEPTH];
    logic         m_hit;
    nh_entry_t    m_entry;
    match_stage_t s1_d, s1_q;
    result_t      out_d, out_q;

    assign wr_entry = '{valid: cp_wr_valid, key: cp_wr_key, act: cp_wr_act,
                        nhop: cp_wr_nhop, port: cp_wr_port};

    nh_entry_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cp_wr_en),
        .wr_idx   (cp_wr_idx),
        .wr_entry (wr_entry),
        .tbl_o    (tbl)
    );

    nh_match #(.DEPTH(DEPTH)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_i   (lk_dst),
        .tbl_i   (tbl),
        .hit_o   (m_hit),
        .entry_o (m_entry)
    );

    always_comb begin
        // stage 1: capture the match outcome
        s1_d       = '0;
        s1_d.valid = lk_req;
        if (lk_req && m_hit) begin
            s1_d.hit  = 1'b1;
            s1_d.act  = m_entry.act;
            s1_d.nhop = m_entry.nhop;
            s1_d.port = m_entry.port;
        end
        // stage 2: execute the action (default action is drop)
        out_d = '0;
        if (s1_q.valid) begin
            out_d.valid = 1'b1;
            out_d.hit   = s1_q.hit;
            if (s1_q.hit && s1_q.act == ACT_SET_NHOP) begin
                out_d.port = s1_q.port;
                out_d.nhop = s1_q.nhop;
            end else begin
                out_d.port = DROP_PORT;
            end
            out_d.drop = (out_d.port == DROP_PORT);
            if (out_d.drop) begin
                out_d.nhop = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q  <= '0;
            out_q <= '0;
        end else begin
            s1_q  <= s1_d;
            out_q <= out_d;
        end
    end

    assign rs_valid = out_q.valid;
    assign rs_hit   = out_q.hit;
    assign rs_drop  = out_q.drop;
    assign rs_nhop  = out_q.nhop;
    assign rs_port  = out_q.port;

    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> ##1 rs_valid);
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> ##1 !rs_valid);
    p_miss_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && !rs_hit) |-> (rs_drop && rs_port == DROP_PORT));
    p_drop_no_nhop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rs_drop |-> (rs_nhop == '0 && rs_port == DROP_PORT));
    p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_valid |-> (!rs_hit && !rs_drop && rs_nhop == '0 && rs_port == '0));
endmodule

// File: tb/sim_nh_lookup_stage.sv
`timescale 1ns/1ps
module sim_nh_lookup_stage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cp_wr_en = 1'b0;
    logic [3:0]  cp_wr_idx = '0;
    logic [31:0] cp_wr_key = '0;
    logic [1:0]  cp_wr_act = '0;
    logic [31:0] cp_wr_nhop = '0;
    logic [11:0] cp_wr_port = '0;
    logic        cp_wr_valid = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_dst = '0;
    logic        rs_valid, rs_hit, rs_drop;
    logic [31:0] rs_nhop;
    logic [11:0] rs_port;

    always #2.5 clk = ~clk;

    nh_lookup_stage u0 (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference table
    logic        m_v   [16];
    logic [31:0] m_key [16];
    logic [1:0]  m_act [16];
    logic [31:0] m_nh  [16];
    logic [11:0] m_pt  [16];

    // expected-result pipeline, two deep
    logic        e_v [2], e_h [2], e_d [2];
    logic [31:0] e_n [2];
    logic [11:0] e_p [2];
    string       e_t [2];

    logic [31:0] pool [8];

    task automatic compare(input string tag, input logic v, h, d,
                           input logic [31:0] n, input logic [11:0] p);
        checks++;
        if (rs_valid !== v || rs_hit !== h || rs_drop !== d ||
            rs_nhop !== n || rs_port !== p) begin
            fails++;
            $display("FAIL %s: got v=%0b h=%0b d=%0b nh=%h p=%h exp v=%0b h=%0b d=%0b nh=%h p=%h",
                     tag, rs_valid, rs_hit, rs_drop, rs_nhop, rs_port, v, h, d, n, p);
        end
    endtask

    task automatic step(input logic we, input logic [3:0] wi, input logic [31:0] wk,
                        input logic [1:0] wa, input logic [31:0] wn, input logic [11:0] wp,
                        input logic wv, input logic rq, input logic [31:0] rk,
                        input string tag);
        int   hit_i;
        logic ev, eh, ed;
        logic [31:0] en;
        logic [11:0] ep;
        string et;
        @(negedge clk);
        compare(e_t[1], e_v[1], e_h[1], e_d[1], e_n[1], e_p[1]);
        e_v[1] = e_v[0]; e_h[1] = e_h[0]; e_d[1] = e_d[0];
        e_n[1] = e_n[0]; e_p[1] = e_p[0]; e_t[1] = e_t[0];
        // expected from table before this cycle's write (R9)
        hit_i = -1;
        for (int i = 15; i >= 0; i--) begin
            if (m_v[i] && m_key[i] == rk) hit_i = i;
        end
        ev = rq; eh = 0; ed = 0; en = '0; ep = '0; et = "R11";
        if (rq) begin
            if (hit_i < 0) begin
                ed = 1; ep = 12'hFFF; et = "R5";
            end else begin
                eh = 1;
                if (m_act[hit_i] != 2'b01) begin
                    ed = 1; ep = 12'hFFF; et = "R4";
                end else if (m_pt[hit_i] == 12'hFFF) begin
                    ed = 1; ep = 12'hFFF; et = "R10";
                end else begin
                    en = m_nh[hit_i]; ep = m_pt[hit_i]; et = "R3";
                end
            end
        end
        if (tag != "") et = tag;
        e_v[0] = ev; e_h[0] = eh; e_d[0] = ed; e_n[0] = en; e_p[0] = ep; e_t[0] = et;
        if (we) begin
            m_v[wi] = wv; m_key[wi] = wk; m_act[wi] = wa; m_nh[wi] = wn; m_pt[wi] = wp;
        end
        cp_wr_en = we; cp_wr_idx = wi; cp_wr_key = wk; cp_wr_act = wa;
        cp_wr_nhop = wn; cp_wr_port = wp; cp_wr_valid = wv;
        lk_req = rq; lk_dst = rk;
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        int unsigned seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        for (int i = 0; i < 16; i++) begin
            m_v[i] = 0; m_key[i] = 0; m_act[i] = 0; m_nh[i] = 0; m_pt[i] = 0;
        end
        for (int i = 0; i < 2; i++) begin
            e_v[i] = 0; e_h[i] = 0; e_d[i] = 0; e_n[i] = 0; e_p[i] = 0; e_t[i] = "R1";
        end
        for (int i = 0; i < 8; i++) pool[i] = 32'h0A00_0000 + i * 32'h0001_0101;
        repeat (4) @(posedge clk);
        @(negedge clk);
        compare("R1", 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        // R1: lookup with empty table misses
        step(0, 0, 0, 0, 0, 0, 0, 1, 32'h0A00_0001, "R1");
        idle("");
        // R9: write and lookup on the same edge -> old (miss); next cycle -> hit
        step(1, 5, 32'hC0A8_0101, 2'b01, 32'h0A0A_0A01, 12'h123, 1, 1, 32'hC0A8_0101, "R9");
        step(0, 0, 0, 0, 0, 0, 0, 1, 32'hC0A8_0101, "R9");
        // R2: one bit off misses
        step(0, 0, 0, 0, 0, 0, 0, 1, 32'hC0A8_0100, "R2");
        step(0, 0, 0, 0, 0, 0, 0, 1, 32'h40A8_0101, "R2");
        // R7: duplicate key at lower index wins
        step(1, 2, 32'hC0A8_0101, 2'b01, 32'h0B0B_0B02, 12'h055, 1, 0, 0, "");
        step(0, 0, 0, 0, 0, 0, 0, 1, 32'hC0A8_0101, "R7");
        // R6: invalidate index 2 -> index 5 answers again
        step(1, 2, 32'hC0A8_0101, 2'b01, 32'h0B0B_0B02, 12'h055, 0, 0, 0, "");
        step(0, 0, 0, 0, 0, 0, 0, 1, 32'hC0A8_0101, "R6");
        // R4: drop action on a hit
        step(1, 7, 32'h0808_0808, 2'b00, 32'h1111_1111, 12'h0AA, 1, 0, 0, "");
        step(0, 0, 0, 0, 0, 0, 0, 1, 32'h0808_0808, "R4");
        // R10: set-next-hop with reserved port reports drop
        step(1, 8, 32'h0909_0909, 2'b01, 32'h2222_2222, 12'hFFF, 1, 0, 0, "");
        step(0, 0, 0, 0, 0, 0, 0, 1, 32'h0909_0909, "R10");
        // R8: back-to-back requests
        step(0, 0, 0, 0, 0, 0, 0, 1, 32'hC0A8_0101, "R8");
        step(0, 0, 0, 0, 0, 0, 0, 1, 32'h0808_0808, "R8");
        step(0, 0, 0, 0, 0, 0, 0, 1, 32'h0102_0304, "R8");
        idle("R11");
        // constrained random traffic
        for (int c = 0; c < 4000; c++) begin
            logic we, wv, rq;
            logic [11:0] wp;
            logic [31:0] rk;
            we = ($urandom % 10) < 3;
            wv = ($urandom % 8) != 0;
            wp = (($urandom % 8) == 0) ? 12'hFFF : 12'($urandom);
            rq = ($urandom % 10) < 7;
            rk = (($urandom % 6) == 0) ? $urandom : pool[$urandom % 8];
            step(we, 4'($urandom), pool[$urandom % 8], 2'($urandom), $urandom,
                 wp, wv, rq, rk, "");
        end
        idle("");
        idle("");
        idle("");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got no finish, expected end of stimulus");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule